// File: doc/BRIEF.md
# Prioritised Interrupt Entry Sequencer

This block is the interrupt-taking part of a small 8-bit controller core. It watches two request lines, one from an external pin and one from an on-chip timer. It remembers each new request in a pending flag. When a flag is pending and the core's interrupt mask bit is clear, the block saves the machine state and jumps to a handler.

To save the state, it writes the program counter, the index register, the accumulator and the condition codes to a downward-growing stack through a byte write port. It then reads a 16-bit handler address through a byte read port. Finally it presents that address as the new program counter and tells the core to set its mask bit. The whole entry takes a fixed number of cycles, and a busy output stays high for all of them.

After reset, the block fetches the start address from a fixed reset vector and delivers it the same way. The surrounding core supplies the register values and the stack pointer. It owns the mask bit and it performs the memory accesses. The address bus is only `ADDR_W` bits wide, so each vector location is truncated to that width.

Top module: `irq_entry_seq`

## Requirements
- R1: A low-to-high change on `ext_req` or `tmr_req`, seen between two clock edges, sets that source's pending flag (`pend_ext` or `pend_tmr`) at the next edge.
- R2: A pending flag stays set while its request input is low or is held high. It is cleared only when its own source is serviced.
- R3: An entry starts only from idle, and only when at least one flag is pending and `mask_flag` is 0. While `mask_flag` is 1, `busy` stays low and the pending flags are kept.
- R4: The entry writes five bytes, one per cycle, starting at the address `sp_in` held when the entry began. The order is PC low byte at SP, PC high byte at SP-1, X at SP-2, A at SP-3 and CC at SP-4.
- R5: When both flags are pending at the start of an entry, the external source is serviced. Only the serviced source's flag is cleared; the other flag stays set and is serviced by a later entry.
- R6: The handler address is read high byte first. The external source uses 0xFFFA/0xFFFB and the timer uses 0xFFF8/0xFFF9, each truncated to the low `ADDR_W` bits. The address is presented on `pc_out` in the single cycle where `pc_load` is 1, and `set_mask` is 1 in that same cycle.
- R7: Every interrupt entry holds `busy` high for exactly `ENTRY_CYCLES` (11) consecutive cycles, and the last of them is the `pc_load` cycle.
- R8: While reset is applied, both pending flags are 0 and `busy` is 1. After reset, the block reads `RESET_VEC` (0xFFF6) high byte and then `RESET_VEC+1` low byte, both truncated. It then pulses `pc_load` with that value and `set_mask` at 0, and returns to idle.
- R9: A request that rises while an entry is running is captured as pending and is not lost when that entry completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req | input | 1 | External interrupt request, edge captured |
| tmr_req | input | 1 | Timer interrupt request, edge captured |
| mask_flag | input | 1 | Interrupt mask bit from the condition codes |
| pc_in | input | 16 | Program counter to be saved |
| x_in | input | 8 | Index register to be saved |
| a_in | input | 8 | Accumulator to be saved |
| cc_in | input | 8 | Condition codes to be saved |
| sp_in | input | ADDR_W | Stack pointer at entry start |
| mem_we | output | 1 | Stack byte write strobe |
| mem_waddr | output | ADDR_W | Stack write address |
| mem_wdata | output | 8 | Stack write data |
| mem_re | output | 1 | Vector byte read strobe |
| mem_raddr | output | ADDR_W | Vector read address |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| pc_out | output | 16 | Fetched vector, new program counter |
| pc_load | output | 1 | One-cycle pulse: load `pc_out` into PC |
| set_mask | output | 1 | One-cycle pulse: set the interrupt mask bit |
| busy | output | 1 | Reset fetch or interrupt entry in progress |
| pend_ext | output | 1 | External request pending |
| pend_tmr | output | 1 | Timer request pending |

## Verification
The hardest situations to reach from the ports are those where the two sources overlap. One is both flags pending at the same start edge. The other is a timer request arriving in the middle of an external entry, which must survive that entry's clear.

The bench sweeps twelve entries over external-only, timer-only and simultaneous requests. Each entry uses a different stack pointer, register contents and vector bytes. The requests are pulsed and dropped while the mask is held, so the capture and hold behaviour is seen before any entry begins. In one external entry, the timer line is raised during the third busy cycle. For every entry, the bench then compares the stored bytes, the loaded address, the busy length and both flags with values it computes itself.

// File: rtl/irq_seq_pkg.sv
// Package: shared constants and types for the interrupt entry sequencer.
// Assumes the vector constants are full 16-bit values that the datapath
// truncates to its own address width.
package irq_seq_pkg;
    typedef enum logic [1:0] {
        PH_BOOT  = 2'd0,
        PH_IDLE  = 2'd1,
        PH_ENTRY = 2'd2
    } phase_t;

    localparam int SRC_EXT = 0;
    localparam int SRC_TMR = 1;
    localparam int NUM_SRC = 2;

    localparam logic [15:0] VEC_EXT = 16'hFFFA;
    localparam logic [15:0] VEC_TMR = 16'hFFF8;

    // Entry schedule: cycles 0..4 push, 5 and 6 read the vector.
    localparam int PUSH_BYTES = 5;
    localparam int ENT_RD_HI  = 5;
    localparam int ENT_RD_LO  = 6;
    // Boot schedule: cycle 0 reads high, 1 reads low, 2 loads.
    localparam int BOOT_LOAD  = 2;
endpackage

// File: rtl/irq_pend_latch.sv
// Module: irq_pend_latch
// Captures a rising edge on each request line into a sticky pending flag.
// A flag clears only on its own clear pulse. A new edge in the same cycle
// as the clear wins, so no request is lost. Assumes the requests are
// synchronous to clk.
module irq_pend_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] req_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        // Track the previous level and update the sticky flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[i] <= 1'b0;
                pend[i]  <= 1'b0;
            end else begin
                req_q[i] <= req[i];
                pend[i]  <= (req[i] & ~req_q[i]) | (pend[i] & ~clr[i]);
            end
        end

        assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req[i]) |=> pend[i]);

        assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr[i]) |=> pend[i]);
    end
endmodule

// File: rtl/irq_entry_ctl.sv
// Module: irq_entry_ctl
// Phase machine for the reset-vector fetch and for interrupt entry:
// five stack pushes, two vector reads, then a PC load with a mask-set
// pulse. Assumes ENTRY_CYCLES >= 8 and that read data is combinational
// on mem_raddr.
module irq_entry_ctl
    import irq_seq_pkg::*;
#(
    parameter int          ADDR_W       = 12,
    parameter int          ENTRY_CYCLES = 11,
    parameter logic [15:0] RESET_VEC    = 16'hFFF6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    pend,
    input  logic                  mask_flag,
    input  logic [15:0]           pc_in,
    input  logic [7:0]            x_in,
    input  logic [7:0]            a_in,
    input  logic [7:0]            cc_in,
    input  logic [ADDR_W-1:0]     sp_in,
    input  logic [7:0]            mem_rdata,
    output logic [NUM_SRC-1:0]    clr,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_waddr,
    output logic [7:0]            mem_wdata,
    output logic                  mem_re,
    output logic [ADDR_W-1:0]     mem_raddr,
    output logic [15:0]           pc_out,
    output logic                  pc_load,
    output logic                  set_mask,
    output logic                  busy
);
    localparam int CW = $clog2(ENTRY_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(ENTRY_CYCLES - 1);

    phase_t            phase;
    logic [CW-1:0]     cnt;
    logic              src_tmr;
    logic [ADDR_W-1:0] sp_r;
    logic [15:0]       pc_r;
    logic [7:0]        x_r, a_r, cc_r, vec_hi, vec_lo;
    logic              start, rd_hi, rd_lo, in_boot, in_entry;
    logic [15:0]       vec_base, vec_addr;

    assign in_boot  = (phase == PH_BOOT);
    assign in_entry = (phase == PH_ENTRY);
    assign start    = (phase == PH_IDLE) && (|pend) && !mask_flag;

    // Advance the phase counter and snapshot state at entry start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_BOOT;
            cnt     <= '0;
            src_tmr <= 1'b0;
            sp_r    <= '0;
            pc_r    <= '0;
            x_r     <= '0;
            a_r     <= '0;
            cc_r    <= '0;
        end else begin
            case (phase)
                PH_BOOT: begin
                    if (cnt == CW'(BOOT_LOAD)) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_ENTRY;
                        cnt     <= '0;
                        src_tmr <= !pend[SRC_EXT];
                        sp_r    <= sp_in;
                        pc_r    <= pc_in;
                        x_r     <= x_in;
                        a_r     <= a_in;
                        cc_r    <= cc_in;
                    end
                end
                default: begin
                    if (cnt == LAST) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Capture the vector bytes as they are read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_hi <= '0;
            vec_lo <= '0;
        end else begin
            if (rd_hi) vec_hi <= mem_rdata;
            if (rd_lo) vec_lo <= mem_rdata;
        end
    end

    // Decode the read slots and the vector address.
    always_comb begin
        rd_hi    = (in_boot && cnt == CW'(0)) || (in_entry && cnt == CW'(ENT_RD_HI));
        rd_lo    = (in_boot && cnt == CW'(1)) || (in_entry && cnt == CW'(ENT_RD_LO));
        vec_base = in_boot ? RESET_VEC : (src_tmr ? VEC_TMR : VEC_EXT);
        vec_addr = vec_base + {15'd0, rd_lo};
    end

    assign mem_re    = rd_hi | rd_lo;
    assign mem_raddr = vec_addr[ADDR_W-1:0];

    // Select the pushed byte for the current stack slot.
    always_comb begin
        mem_we    = in_entry && (cnt < CW'(PUSH_BYTES));
        mem_waddr = sp_r - {{(ADDR_W-CW){1'b0}}, cnt};
        case (cnt)
            CW'(0):  mem_wdata = pc_r[7:0];
            CW'(1):  mem_wdata = pc_r[15:8];
            CW'(2):  mem_wdata = x_r;
            CW'(3):  mem_wdata = a_r;
            default: mem_wdata = cc_r;
        endcase
    end

    assign pc_out   = {vec_hi, vec_lo};
    assign pc_load  = (in_boot && cnt == CW'(BOOT_LOAD)) || (in_entry && cnt == LAST);
    assign set_mask = in_entry && (cnt == LAST);
    assign clr      = set_mask ? (src_tmr ? 2'b10 : 2'b01) : 2'b00;
    assign busy     = (phase != PH_IDLE);

    assert_stack_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_waddr == $past(mem_waddr) - 1'b1));

    assert_mask_with_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_mask |-> (pc_load && busy && !mem_we));

    assert_masked_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mask_flag) |=> !busy);
endmodule

// File: rtl/irq_entry_seq.sv
// Module: irq_entry_seq (top)
// Joins the pending-flag latch and the entry phase machine. The core
// supplies the register values and owns the mask bit and the memory.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int          ADDR_W       = 12,
    parameter int          ENTRY_CYCLES = 11,
    parameter logic [15:0] RESET_VEC    = 16'hFFF6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req,
    input  logic              tmr_req,
    input  logic              mask_flag,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        x_in,
    input  logic [7:0]        a_in,
    input  logic [7:0]        cc_in,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    output logic [15:0]       pc_out,
    output logic              pc_load,
    output logic              set_mask,
    output logic              busy,
    output logic              pend_ext,
    output logic              pend_tmr
);
    logic [NUM_SRC-1:0] pend, clr;

    irq_pend_latch #(.N(NUM_SRC)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({tmr_req, ext_req}),
        .clr   (clr),
        .pend  (pend)
    );

    irq_entry_ctl #(
        .ADDR_W       (ADDR_W),
        .ENTRY_CYCLES (ENTRY_CYCLES),
        .RESET_VEC    (RESET_VEC)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .mask_flag (mask_flag),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .a_in      (a_in),
        .cc_in     (cc_in),
        .sp_in     (sp_in),
        .mem_rdata (mem_rdata),
        .clr       (clr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_raddr (mem_raddr),
        .pc_out    (pc_out),
        .pc_load   (pc_load),
        .set_mask  (set_mask),
        .busy      (busy)
    );

    assign pend_ext = pend[SRC_EXT];
    assign pend_tmr = pend[SRC_TMR];

    assert_single_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr) && (clr == 2'b00 || pc_load));
endmodule

// File: tb/irq_entry_seq_bench.sv
// Bench: sweeps interrupt entries over source mixes, register contents and
// stack positions, with expected bytes computed from the requirements.
module irq_entry_seq_bench;
    localparam int ADDR_W = 12;
    localparam int NCYC   = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_req = 1'b0, tmr_req = 1'b0, mask_flag = 1'b1;
    logic [15:0]       pc_in = '0;
    logic [7:0]        x_in = '0, a_in = '0, cc_in = '0;
    logic [ADDR_W-1:0] sp_in = '0;
    logic              mem_we, mem_re, pc_load, set_mask, busy, pend_ext, pend_tmr;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [7:0]        mem_wdata, mem_rdata;
    logic [15:0]       pc_out;

    logic [7:0] mem [0:(1<<ADDR_W)-1];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_entry_seq #(.ADDR_W(ADDR_W), .ENTRY_CYCLES(NCYC), .RESET_VEC(16'hFFF6)) u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .tmr_req(tmr_req),
        .mask_flag(mask_flag), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
        .cc_in(cc_in), .sp_in(sp_in), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata), .pc_out(pc_out), .pc_load(pc_load),
        .set_mask(set_mask), .busy(busy), .pend_ext(pend_ext), .pend_tmr(pend_tmr)
    );

    // Memory model: write on the edge, combinational read.
    always @(posedge clk) if (mem_we) mem[mem_waddr] <= mem_wdata;
    assign mem_rdata = mem[mem_raddr];

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Clear the mask and wait for the entry to finish; returns busy count and PC.
    task automatic run_entry(input bit inject_tmr, output int nbusy,
                             output logic [15:0] got_pc, output logic got_sm);
        nbusy  = 0;
        got_pc = 16'h0;
        got_sm = 1'b0;
        mask_flag = 1'b0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (busy) nbusy++;
            if (inject_tmr && nbusy == 3) tmr_req = 1'b1;
            if (inject_tmr && nbusy == 4) tmr_req = 1'b0;
            if (pc_load) begin
                got_pc = pc_out;
                got_sm = set_mask;
                mask_flag = 1'b1;
                break;
            end
        end
        @(negedge clk);
    endtask

    // Check the five stacked bytes below sp.
    task automatic check_stack(input logic [ADDR_W-1:0] sp, input logic [15:0] pc,
                               input logic [7:0] x, input logic [7:0] a, input logic [7:0] cc);
        check("R4", "stack PCL", {8'h0, mem[sp]}, {8'h0, pc[7:0]});
        check("R4", "stack PCH", {8'h0, mem[sp - 1]}, {8'h0, pc[15:8]});
        check("R4", "stack X",   {8'h0, mem[sp - 2]}, {8'h0, x});
        check("R4", "stack A",   {8'h0, mem[sp - 3]}, {8'h0, a});
        check("R4", "stack CC",  {8'h0, mem[sp - 4]}, {8'h0, cc});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nb;
        logic [15:0] pc_g, ev, tv;
        logic sm;
        bit seen;
        for (int i = 0; i < (1<<ADDR_W); i++) mem[i] = 8'h00;
        mem[12'hFF6] = 8'h0A;
        mem[12'hFF7] = 8'h55;

        // R8: reset state, then reset-vector load.
        repeat (3) @(negedge clk);
        check("R8", "pend_ext in reset", {15'h0, pend_ext}, 16'h0);
        check("R8", "pend_tmr in reset", {15'h0, pend_tmr}, 16'h0);
        check("R8", "busy in reset", {15'h0, busy}, 16'h1);
        rst_n = 1'b1;
        seen = 1'b0;
        for (int t = 0; t < 10 && !seen; t++) begin
            @(negedge clk);
            if (pc_load) begin
                seen = 1'b1;
                check("R8", "reset vector", pc_out, 16'h0A55);
                check("R8", "set_mask on boot", {15'h0, set_mask}, 16'h0);
            end
        end
        check("R8", "boot load seen", {15'h0, seen}, 16'h1);
        @(negedge clk);
        check("R8", "idle after boot", {15'h0, busy}, 16'h0);

        // R3 and R2: masked request is held, no entry starts.
        ext_req = 1'b1;
        @(negedge clk);
        ext_req = 1'b0;
        seen = 1'b0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
        end
        check("R3", "no entry while masked", {15'h0, seen}, 16'h0);
        check("R2", "pend_ext held after drop", {15'h0, pend_ext}, 16'h1);
        check("R1", "pend_tmr untouched", {15'h0, pend_tmr}, 16'h0);

        // Service the held external request once to start clean.
        mem[12'hFFA] = 8'hC1;
        mem[12'hFFB] = 8'h23;
        sp_in = 12'h0FF;
        run_entry(1'b0, nb, pc_g, sm);
        check("R6", "first ext vector", pc_g, 16'hC123);
        check("R5", "pend_ext cleared", {15'h0, pend_ext}, 16'h0);

        // Sweep: k%3 = 0 external, 1 timer, 2 both at once.
        for (int k = 0; k < 12; k++) begin
            int mode = k % 3;
            bit inject = (k == 3);
            ev = {8'h80 + 8'(k), 8'(k * 5)};
            tv = {8'h40 + 8'(k), ~8'(k)};
            mem[12'hFFA] = ev[15:8];
            mem[12'hFFB] = ev[7:0];
            mem[12'hFF8] = tv[15:8];
            mem[12'hFF9] = tv[7:0];
            pc_in = 16'h1000 + 16'(k) * 16'h0123;
            x_in  = 8'(k * 7 + 1);
            a_in  = 8'hA0 ^ 8'(k);
            cc_in = 8'hE0 | 8'(k);
            sp_in = 12'h0FF - 12'(k * 3);

            @(negedge clk);
            ext_req = (mode != 1);
            tmr_req = (mode != 0);
            @(negedge clk);
            ext_req = 1'b0;
            tmr_req = 1'b0;
            @(negedge clk);
            check("R1", "pend_ext after edge", {15'h0, pend_ext}, {15'h0, mode != 1});
            check("R2", "pend_tmr after drop", {15'h0, pend_tmr}, {15'h0, mode != 0});

            run_entry(inject, nb, pc_g, sm);
            check("R7", "busy cycles", 16'(nb), 16'(NCYC));
            check("R6", "set_mask with load", {15'h0, sm}, 16'h1);
            check_stack(sp_in, pc_in, x_in, a_in, cc_in);
            if (mode == 1) begin
                check("R6", "timer vector", pc_g, tv);
                check("R5", "timer cleared", {15'h0, pend_tmr}, 16'h0);
            end else begin
                check("R5", "ext vector first", pc_g, ev);
                check("R5", "ext cleared", {15'h0, pend_ext}, 16'h0);
            end
            if (mode == 2 || inject) begin
                if (inject)
                    check("R9", "mid-entry timer kept", {15'h0, pend_tmr}, 16'h1);
                else
                    check("R5", "timer kept pending", {15'h0, pend_tmr}, 16'h1);
                sp_in = sp_in - 12'h010;
                run_entry(1'b0, nb, pc_g, sm);
                check("R6", "second entry timer vector", pc_g, tv);
                check("R7", "second entry busy cycles", 16'(nb), 16'(NCYC));
                check_stack(sp_in, pc_in, x_in, a_in, cc_in);
            end
            check("R5", "all clear ext", {15'h0, pend_ext}, 16'h0);
            check("R5", "all clear tmr", {15'h0, pend_tmr}, 16'h0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule